// File: doc/BRIEF.md
# Distributed Daisy-Chain Bus Arbitration

This block decides bus ownership among a set of devices without any central arbiter. Every device has an identical arbitration cell. All cells share a wired request line and a wired busy line. A priority token runs through the cells in order, entering each cell on its chain input and leaving on its chain output. Open-collector wiring is modelled as logical OR for the request and busy lines.

The head of the chain drives the first cell's chain input high whenever any device requests. A requesting cell whose chain input is high while the bus is idle pulls its chain output low at once, which cuts off every device below it. It then holds that output low for one more cycle and checks again. If it is still eligible, it raises busy and owns the bus. A device closer to the head that starts requesting during that check cycle removes the lower cell's eligibility, so it takes priority. Each device reports a transfer length. The owner keeps the bus for that many cycles and then lets its chain output follow its input again.

Top module: `dchain_arb_top`

## Requirements
- R1: After reset, no device holds a grant, busy is low, and with no requests every chain output is low.
- R2: The chain head is driven with the OR of all requests. A cell that is not requesting passes its chain input to its chain output within the same cycle. When only device k requests on an idle bus, the chain outputs of devices 0..k-1 read 1 and those of k..N-1 read 0 in the cycle the request is raised.
- R3: A requesting device on an idle bus whose chain input is high pulls its chain output low in that same cycle. If it stays eligible, its grant rises two clock edges after its request was first seen, which is never in a cycle where busy was already high.
- R4: At most one grant is high at any time. When several devices request together, they are served in ascending index order (index 0 is nearest the head and has the highest priority).
- R5: The owner keeps its grant, and busy stays high, for exactly its transfer length in cycles. The length is sampled from `len_i` when ownership is taken, and a length of 0 counts as 1.
- R6: Busy falls in the same cycle the grant falls. The next grant starts two cycles after the previous grant ended.
- R7: If a device nearer the head starts requesting during a lower device's check cycle, the lower device's claim is dropped. The nearer device is granted first, and the lower device is served after it.
- R8: An ongoing transfer cannot be preempted. A request raised while busy is high waits until busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_DEV | Per-device bus request (level) |
| len_i | input | N_DEV*LEN_W | Per-device transfer length in cycles; device k uses slice [k*LEN_W +: LEN_W] |
| grant_o | output | N_DEV | Per-device ownership indication |
| busy_o | output | 1 | Shared busy line (OR of owners) |
| bus_req_o | output | 1 | Shared request line (OR of requests) |
| arb_out_o | output | N_DEV | Chain output of each device's cell |

## Verification
The chain outputs are combinational, so the bench reads them 1 ns after it drives the request in the same cycle. Grants come two edges after a request on an idle bus. A grant lasts for the transfer length, and the next one follows two cycles after it ends. The bench turns these delays into a start cycle for each device and compares grant and busy on every cycle of each scenario. The sweep covers every request subset under several length sets, including length 0 and the maximum length. It also includes a preemption during a check cycle and a request raised during a transfer.

// File: rtl/dchain_arb_pkg.sv
package dchain_arb_pkg;

    typedef enum logic [1:0] {
        CELL_IDLE  = 2'd0,
        CELL_CHECK = 2'd1,
        CELL_OWN   = 2'd2
    } cell_state_e;

endpackage

// File: rtl/dchain_arb_head.sv
module dchain_arb_head #(
    parameter int N_DEV = 4
) (
    input  logic [N_DEV-1:0] want_i,
    input  logic [N_DEV-1:0] own_i,
    output logic             bus_req_o,
    output logic             busy_o,
    output logic             head_arb_o
);
    // Wired-OR shared lines modelled logically
    always_comb begin
        bus_req_o  = |want_i;
        busy_o     = |own_i;
        head_arb_o = |want_i;
    end
endmodule

// File: rtl/dchain_arb_cell.sv
module dchain_arb_cell
    import dchain_arb_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             want_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             busy_i,
    input  logic             chain_in_i,
    output logic             chain_out_o,
    output logic             own_o
);
    localparam logic [LEN_W-1:0] CNT_ONE = {{(LEN_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        cell_state_e      st;
        logic [LEN_W-1:0] cnt;
    } cell_regs_t;

    cell_regs_t r_d, r_q;
    logic       eligible;

    always_comb begin
        r_d         = r_q;
        eligible    = want_i && chain_in_i && !busy_i;
        chain_out_o = chain_in_i;
        unique case (r_q.st)
            CELL_IDLE: begin
                if (eligible) begin
                    chain_out_o = 1'b0;
                    r_d.st      = CELL_CHECK;
                end
            end
            CELL_CHECK: begin
                chain_out_o = 1'b0;
                if (eligible) begin
                    r_d.st  = CELL_OWN;
                    r_d.cnt = (len_i == '0) ? '0 : (len_i - CNT_ONE);
                end else begin
                    r_d.st = CELL_IDLE;
                end
            end
            CELL_OWN: begin
                chain_out_o = 1'b0;
                if (r_q.cnt == '0) begin
                    r_d.st = CELL_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_ONE;
                end
            end
            default: r_d.st = CELL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st  <= CELL_IDLE;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign own_o = (r_q.st == CELL_OWN);

    // R5: a transfer with cycles remaining keeps ownership next cycle
    a_r5_hold_len: assert property (@(posedge clk) disable iff (!rst_n)
        (own_o && r_q.cnt != '0) |=> own_o);

    // R7: a check cycle without eligibility never yields ownership
    a_r7_abort_claim: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == CELL_CHECK && !chain_in_i) |=> !own_o);

endmodule

// File: rtl/dchain_arb_top.sv
module dchain_arb_top #(
    parameter int N_DEV = 4,
    parameter int LEN_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_DEV-1:0]       req_i,
    input  logic [N_DEV*LEN_W-1:0] len_i,
    output logic [N_DEV-1:0]       grant_o,
    output logic                   busy_o,
    output logic                   bus_req_o,
    output logic [N_DEV-1:0]       arb_out_o
);
    logic chain [0:N_DEV];
    logic head_arb;

    dchain_arb_head #(.N_DEV(N_DEV)) u_head (
        .want_i     (req_i),
        .own_i      (grant_o),
        .bus_req_o  (bus_req_o),
        .busy_o     (busy_o),
        .head_arb_o (head_arb)
    );

    assign chain[0] = head_arb;

    for (genvar k = 0; k < N_DEV; k++) begin : g_cell
        dchain_arb_cell #(.LEN_W(LEN_W)) u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .want_i      (req_i[k]),
            .len_i       (len_i[k*LEN_W +: LEN_W]),
            .busy_i      (busy_o),
            .chain_in_i  (chain[k]),
            .chain_out_o (chain[k+1]),
            .own_o       (grant_o[k])
        );
        assign arb_out_o[k] = chain[k+1];

        // R3: ownership is only taken from a bus that was idle
        a_r3_idle_take: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(grant_o[k]) |-> !$past(busy_o));

        // R6: busy is released together with the grant
        a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(grant_o[k]) |-> !busy_o);
    end

    // R4: never two owners
    a_r4_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // R2: no requests means no token anywhere on the chain
    a_r2_no_token: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req_o |-> (arb_out_o == '0));

endmodule

// File: tb/dchain_arb_top_bench.sv
module dchain_arb_top_bench;
    localparam int N  = 4;
    localparam int LW = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [N-1:0]    req;
    logic [N*LW-1:0] len;
    logic [N-1:0]    grant;
    logic            busy;
    logic            breq;
    logic [N-1:0]    arbo;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dchain_arb_top #(.N_DEV(N), .LEN_W(LW)) u_dchain_arb_top (
        .clk(clk), .rst_n(rst_n), .req_i(req), .len_i(len),
        .grant_o(grant), .busy_o(busy), .bus_req_o(breq), .arb_out_o(arbo)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // raise[k] < 0: device k never requests; expected grant window [st[k], st[k]+eff)
    task automatic run_events(input int raise[N], input int st[N], input int l[N],
                              input int ncyc, input string tag);
        for (int k = 0; k < N; k++) len[k*LW +: LW] = l[k][LW-1:0];
        for (int c = 0; c < ncyc; c++) begin
            logic [N-1:0] exp;
            @(negedge clk);
            for (int k = 0; k < N; k++) begin
                if (grant[k]) req[k] = 1'b0;
                if (raise[k] == c) req[k] = 1'b1;
            end
            #1;
            for (int k = 0; k < N; k++) begin
                int eff;
                eff    = (l[k] == 0) ? 1 : l[k];
                exp[k] = (raise[k] >= 0) && (c >= st[k]) && (c < st[k] + eff);
            end
            chk(grant == exp, tag, int'(grant), int'(exp));
            chk(busy == |exp, "R5 R6 busy", int'(busy), int'(|exp));
        end
        req = '0;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_sched(input logic [N-1:0] mask, input int l[N]);
        int raise[N];
        int st[N];
        int s = 2;
        int lowest = -1;
        logic [N-1:0] exp_arb;
        for (int k = 0; k < N; k++) begin
            raise[k] = mask[k] ? 0 : -1;
            st[k]    = s;
            if (mask[k]) begin
                if (lowest < 0) lowest = k;
                s += ((l[k] == 0) ? 1 : l[k]) + 2;
            end
        end
        // R2 R3: chain outputs in the request cycle
        for (int k = 0; k < N; k++) len[k*LW +: LW] = l[k][LW-1:0];
        @(negedge clk);
        req = mask;
        #1;
        for (int k = 0; k < N; k++) exp_arb[k] = (k < lowest);
        chk(arbo == exp_arb, "R2 R3 chain", int'(arbo), int'(exp_arb));
        chk(breq == 1'b1, "R2 bus_req", int'(breq), 1);
        // already one cycle in: shift the schedule
        for (int k = 0; k < N; k++) begin
            if (mask[k]) begin
                raise[k] = 0;
                st[k]    = st[k] - 1;
            end
        end
        run_events(raise, st, l, s + 1, "R3 R4 R5 R6 grant");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int ls[3][N];
        ls[0] = '{1, 2, 3, 4};
        ls[1] = '{0, 5, 1, 15};
        ls[2] = '{3, 0, 15, 2};
        rst_n = 1'b0;
        req   = '0;
        len   = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(grant == '0, "R1 grant", int'(grant), 0);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(arbo == '0, "R1 chain", int'(arbo), 0);

        // R4 R5 R6: every request subset under several length sets
        for (int s = 0; s < 3; s++) begin
            for (int m = 1; m < (1 << N); m++) begin
                run_sched(m[N-1:0], ls[s]);
            end
        end

        // R7: device 0 arrives during device 2's check cycle
        begin
            int raise[N] = '{1, -1, 0, -1};
            int st[N]    = '{3, 0, 8, 0};
            int l[N]     = '{3, 1, 4, 1};
            run_events(raise, st, l, 14, "R7 preempt");
        end

        // R8: device 0 arrives while device 2 owns the bus
        begin
            int raise[N] = '{3, -1, 0, -1};
            int st[N]    = '{8, 0, 2, 0};
            int l[N]     = '{2, 1, 4, 1};
            run_events(raise, st, l, 12, "R8 no preempt");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule